// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block decides when a small controller may stop its CPU clock or its main oscillator, and how it comes back. Software asks for a reduced-power state in two steps: it writes a request bit into the mode register, and its very next bus write must put the key byte 0x55 into the key register. Any other write in between, or a wrong key, drops the request. One state, idle, stops only the CPU clock; the other, power-down, also turns the main oscillator off.

An interrupt request ends idle. Power-down ends only through a resume reset. Three sources can start it: a port pin whose wake bit is set and that is held low, a wake-up timer that counts slow ticks, or a USB line that stays non-idle for a set number of reference cycles. The resume reset is a pulse of fixed length, and normal running follows it. The block runs on an always-on reference clock. The slow timer tick arrives as a one-cycle pulse in that clock domain.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is running: cpu_clk_en=1, osc_en=1, wdt_clk_en=1, resume_rst=0.
- R2: Writes decode bus_addr as: 0 = mode register (bit0 asks for idle, bit1 asks for power-down, bit2 keeps the watchdog clock in idle), 1 = key register, 2 = wake enable (bit i enables pin i), 3 = wake-timer select (bits 1:0). A mode write with bit0 or bit1 set arms a request. When the next write goes to address 1 with data 0x55, the requested state begins at that clock edge. If both bits are set, power-down wins.
- R3: In idle, cpu_clk_en=0 and osc_en=1. A high irq_req returns the block to running at the next edge.
- R4: In power-down, cpu_clk_en=0 and osc_en=0.
- R5: An armed request is cancelled by the next write if that write is not 0x55 to the key register. A mode write reloads the request bits, so writing zeros clears them. A key write with no armed request has no effect.
- R6: wdt_clk_en is 1 while running or in resume. In idle it equals bit2 of the last mode write. In power-down it is 0.
- R7: In power-down, a pin that is low and whose wake bit is 1 starts a resume at the next edge. Low pins whose wake bit is 0 have no effect.
- R8: Wake-timer select 0 disables the timer. A select of n (1..3) ends power-down on the WKT_BASE<<(n-1)-th wkt_tick counted since power-down began.
- R9: usb_nonidle held high for USB_WAKE_CYC consecutive cycles in power-down starts a resume. A low cycle restarts the count.
- R10: resume_rst stays high for exactly RST_LEN cycles (RST_LEN of at least 16), with osc_en=1, and the block then runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register write address |
| bus_wdata | input | 8 | Register write data |
| port_pins | input | PORT_W | Port pin levels |
| wkt_tick | input | 1 | One-cycle tick from the slow wake clock |
| usb_nonidle | input | 1 | High while the USB lines are not in idle state |
| irq_req | input | 1 | Pending interrupt, ends idle |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| resume_rst | output | 1 | Resume reset pulse |

## Verification
The checker watches several properties on every cycle. The CPU clock and the watchdog clock are never enabled while the oscillator is off. An interrupt in idle always restores the CPU clock at the next edge. An enabled low pin in power-down always starts a resume. Every resume pulse is exactly RST_LEN cycles long with the oscillator running. Other behaviour appears only in the bench's scenarios: the two-write handshake and every way of cancelling it, the choice between idle and power-down, the exact tick count for each timer select, and the USB window restarting after a gap.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int unsigned ADDR_W = 2;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_KEY  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_WAKE = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_WKT  = 2'd3;

    localparam int unsigned MODE_IDLE_BIT = 0;
    localparam int unsigned MODE_PD_BIT   = 1;
    localparam int unsigned MODE_WDT_BIT  = 2;

    localparam logic [DATA_W-1:0] ENTRY_KEY = 8'h55;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_PDOWN  = 2'd2,
        ST_RESUME = 2'd3
    } pmc_state_e;

endpackage

// File: rtl/pmc_regs.sv
// Register decode and the two-write entry handshake.
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int unsigned PORT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic                enter_idle,
    output logic                enter_pd,
    output logic                wdt_idle,
    output logic [PORT_W-1:0]   wake_en,
    output logic [1:0]          wkt_sel
);

    typedef struct packed {
        logic [1:0]        req;
        logic              wdt_idle;
        logic [PORT_W-1:0] wake_en;
        logic [1:0]        wkt_sel;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        enter_idle = 1'b0;
        enter_pd   = 1'b0;
        if (bus_wr) begin
            // Every write that is not a mode write ends an armed request.
            r_d.req = 2'b00;
            unique case (bus_addr)
                ADDR_MODE: begin
                    r_d.req      = {bus_wdata[MODE_PD_BIT], bus_wdata[MODE_IDLE_BIT]};
                    r_d.wdt_idle = bus_wdata[MODE_WDT_BIT];
                end
                ADDR_KEY: begin
                    if ((r_q.req != 2'b00) && (bus_wdata == ENTRY_KEY)) begin
                        enter_pd   = r_q.req[1];
                        enter_idle = ~r_q.req[1];
                    end
                end
                ADDR_WAKE: r_d.wake_en = bus_wdata[PORT_W-1:0];
                default:   r_d.wkt_sel = bus_wdata[1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wdt_idle = r_q.wdt_idle;
    assign wake_en  = r_q.wake_en;
    assign wkt_sel  = r_q.wkt_sel;

endmodule

// File: rtl/pmc_wake.sv
// Wake-source detection while in power-down.
module pmc_wake #(
    parameter int unsigned PORT_W       = 8,
    parameter int unsigned WKT_BASE     = 1024,
    parameter int unsigned USB_WAKE_CYC = 16200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_active,
    input  logic [PORT_W-1:0] port_pins,
    input  logic [PORT_W-1:0] wake_en,
    input  logic [1:0]        wkt_sel,
    input  logic              wkt_tick,
    input  logic              usb_nonidle,
    output logic              wake_req
);

    localparam int unsigned WKT_MAX = WKT_BASE * 4;
    localparam int unsigned WKT_CW  = $clog2(WKT_MAX + 1);
    localparam int unsigned USB_CW  = $clog2(USB_WAKE_CYC + 1);
    localparam logic [USB_CW-1:0] USB_LAST = USB_CW'(USB_WAKE_CYC - 1);

    typedef struct packed {
        logic [WKT_CW-1:0] wkt_cnt;
        logic [USB_CW-1:0] usb_cnt;
    } wake_t;

    wake_t w_d, w_q;

    logic [PORT_W-1:0] pin_hit;
    logic [WKT_CW-1:0] wkt_limit;
    logic              port_hit;
    logic              wkt_hit;
    logic              usb_hit;

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        assign pin_hit[i] = wake_en[i] & ~port_pins[i];
    end

    always_comb begin
        unique case (wkt_sel)
            2'd1:    wkt_limit = WKT_CW'(WKT_BASE);
            2'd2:    wkt_limit = WKT_CW'(WKT_BASE * 2);
            default: wkt_limit = WKT_CW'(WKT_BASE * 4);
        endcase
    end

    always_comb begin
        w_d      = w_q;
        port_hit = |pin_hit;
        wkt_hit  = (wkt_sel != 2'd0) && wkt_tick &&
                   (w_q.wkt_cnt == (wkt_limit - WKT_CW'(1)));
        usb_hit  = usb_nonidle && (w_q.usb_cnt == USB_LAST);

        if (!pd_active) begin
            w_d.wkt_cnt = '0;
        end else if (wkt_tick && (wkt_sel != 2'd0) && !wkt_hit) begin
            w_d.wkt_cnt = w_q.wkt_cnt + WKT_CW'(1);
        end

        if (!pd_active || !usb_nonidle) begin
            w_d.usb_cnt = '0;
        end else if (w_q.usb_cnt != USB_LAST) begin
            w_d.usb_cnt = w_q.usb_cnt + USB_CW'(1);
        end

        wake_req = pd_active && (port_hit || wkt_hit || usb_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Low-power mode sequencer: run, idle, power-down and resume reset.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned PORT_W       = 8,
    parameter int unsigned WKT_BASE     = 1024,
    parameter int unsigned USB_WAKE_CYC = 16200,
    parameter int unsigned RST_LEN      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              wkt_tick,
    input  logic              usb_nonidle,
    input  logic              irq_req,
    output logic              cpu_clk_en,
    output logic              osc_en,
    output logic              wdt_clk_en,
    output logic              resume_rst
);

    localparam int unsigned RCW = $clog2(RST_LEN + 1);
    localparam logic [RCW-1:0] RCNT_LAST = RCW'(RST_LEN - 1);

    typedef struct packed {
        pmc_state_e     state;
        logic [RCW-1:0] rcnt;
    } seq_t;

    seq_t s_d, s_q;

    logic              enter_idle;
    logic              enter_pd;
    logic              wdt_idle;
    logic [PORT_W-1:0] wake_en;
    logic [1:0]        wkt_sel;
    logic              wake_req;
    logic              pd_active;

    pmc_regs #(
        .PORT_W (PORT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .enter_idle (enter_idle),
        .enter_pd   (enter_pd),
        .wdt_idle   (wdt_idle),
        .wake_en    (wake_en),
        .wkt_sel    (wkt_sel)
    );

    assign pd_active = (s_q.state == ST_PDOWN);

    pmc_wake #(
        .PORT_W       (PORT_W),
        .WKT_BASE     (WKT_BASE),
        .USB_WAKE_CYC (USB_WAKE_CYC)
    ) u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_active   (pd_active),
        .port_pins   (port_pins),
        .wake_en     (wake_en),
        .wkt_sel     (wkt_sel),
        .wkt_tick    (wkt_tick),
        .usb_nonidle (usb_nonidle),
        .wake_req    (wake_req)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_RUN: begin
                if (enter_pd) begin
                    s_d.state = ST_PDOWN;
                end else if (enter_idle) begin
                    s_d.state = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (irq_req) begin
                    s_d.state = ST_RUN;
                end
            end
            ST_PDOWN: begin
                if (wake_req) begin
                    s_d.state = ST_RESUME;
                    s_d.rcnt  = '0;
                end
            end
            default: begin
                if (s_q.rcnt == RCNT_LAST) begin
                    s_d.state = ST_RUN;
                    s_d.rcnt  = '0;
                end else begin
                    s_d.rcnt = s_q.rcnt + RCW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_RUN, rcnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        cpu_clk_en = (s_q.state == ST_RUN) || (s_q.state == ST_RESUME);
        osc_en     = (s_q.state != ST_PDOWN);
        resume_rst = (s_q.state == ST_RESUME);
        unique case (s_q.state)
            ST_IDLE:  wdt_clk_en = wdt_idle;
            ST_PDOWN: wdt_clk_en = 1'b0;
            default:  wdt_clk_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int unsigned PORT_W  = 8,
    parameter int unsigned RST_LEN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              cpu_clk_en,
    input logic              osc_en,
    input logic              wdt_clk_en,
    input logic              resume_rst,
    input logic [PORT_W-1:0] port_pins,
    input logic [PORT_W-1:0] wake_en
);

    localparam int unsigned LCW = $clog2(RST_LEN + 2);

    logic [LCW-1:0] pulse_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_len <= '0;
        end else if (resume_rst) begin
            pulse_len <= pulse_len + LCW'(1);
        end else begin
            pulse_len <= '0;
        end
    end

    // R4: no CPU clock while the oscillator is off
    p_pd_cpu_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !cpu_clk_en);

    // R6: no watchdog clock while the oscillator is off
    p_pd_wdt_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !wdt_clk_en);

    // R3: interrupt in idle restores the CPU clock
    p_idle_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && osc_en && irq_req) |=> cpu_clk_en);

    // R7: enabled low pin in power-down starts a resume
    p_port_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && (|(wake_en & ~port_pins))) |=> resume_rst);

    // R10: oscillator runs during the resume pulse
    p_resume_osc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resume_rst |-> osc_en);

    // R10: pulse length is exactly RST_LEN
    p_resume_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resume_rst) |-> (pulse_len == LCW'(RST_LEN)));

endmodule

bind pwr_mode_ctrl pmc_checker #(
    .PORT_W  (PORT_W),
    .RST_LEN (RST_LEN)
) u_pmc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .cpu_clk_en (cpu_clk_en),
    .osc_en     (osc_en),
    .wdt_clk_en (wdt_clk_en),
    .resume_rst (resume_rst),
    .port_pins  (port_pins),
    .wake_en    (wake_en)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;

    localparam int unsigned PORT_W  = 8;
    localparam int unsigned WBASE   = 4;
    localparam int unsigned UCYC    = 20;
    localparam int unsigned RLEN    = 16;
    localparam int unsigned NV      = 10;

    // Write entry: {valid, addr[1:0], data[7:0]}
    localparam logic [10:0] VEC_W [NV][3] = '{
        '{11'h401, 11'h555, 11'h000},
        '{11'h402, 11'h555, 11'h000},
        '{11'h403, 11'h555, 11'h000},
        '{11'h401, 11'h554, 11'h000},
        '{11'h401, 11'h700, 11'h555},
        '{11'h555, 11'h555, 11'h000},
        '{11'h401, 11'h554, 11'h555},
        '{11'h401, 11'h400, 11'h555},
        '{11'h402, 11'h401, 11'h555},
        '{11'h402, 11'h601, 11'h555}
    };
    // Expected {cpu_clk_en, osc_en} after the writes
    localparam logic [1:0] VEC_E [NV] = '{
        2'b01, 2'b00, 2'b00, 2'b11, 2'b11,
        2'b11, 2'b11, 2'b11, 2'b01, 2'b11
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [PORT_W-1:0] port_pins = '1;
    logic              wkt_tick = 1'b0;
    logic              usb_nonidle = 1'b0;
    logic              irq_req = 1'b0;
    logic              cpu_clk_en, osc_en, wdt_clk_en, resume_rst;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(
        .PORT_W       (PORT_W),
        .WKT_BASE     (WBASE),
        .USB_WAKE_CYC (UCYC),
        .RST_LEN      (RLEN)
    ) i_pwr_mode_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .port_pins   (port_pins),
        .wkt_tick    (wkt_tick),
        .usb_nonidle (usb_nonidle),
        .irq_req     (irq_req),
        .cpu_clk_en  (cpu_clk_en),
        .osc_en      (osc_en),
        .wdt_clk_en  (wdt_clk_en),
        .resume_rst  (resume_rst)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick();
        wkt_tick = 1'b1;
        @(negedge clk);
        wkt_tick = 1'b0;
    endtask

    task automatic recover();
        if (!osc_en) begin
            port_pins[0] = 1'b0;
            @(negedge clk);
            port_pins = '1;
            repeat (RLEN + 1) @(negedge clk);
        end else if (!cpu_clk_en) begin
            irq_req = 1'b1;
            @(negedge clk);
            irq_req = 1'b0;
        end
        chk("recover to run", {cpu_clk_en, osc_en, resume_rst}, 3'b110);
    endtask

    task automatic enter_pd();
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h55);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {cpu_clk_en, osc_en, wdt_clk_en, resume_rst}, 4'b1110);

        wr(2'd2, 8'h01);

        // R2 R3 R4 R5 handshake table
        for (int v = 0; v < NV; v++) begin
            for (int w = 0; w < 3; w++) begin
                if (VEC_W[v][w][10]) wr(VEC_W[v][w][9:8], VEC_W[v][w][7:0]);
            end
            chk($sformatf("R2 R3 R4 R5 handshake vector %0d", v),
                {cpu_clk_en, osc_en}, VEC_E[v]);
            recover();
        end

        // R6 watchdog clock in idle, both settings, and in power-down
        wr(2'd0, 8'h05); wr(2'd1, 8'h55);
        chk("R6 idle keep watchdog", {cpu_clk_en, wdt_clk_en}, 2'b01);
        recover();
        wr(2'd0, 8'h01); wr(2'd1, 8'h55);
        chk("R6 idle stop watchdog", {cpu_clk_en, wdt_clk_en}, 2'b00);
        // R3 interrupt ends idle after one edge
        irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
        chk("R3 irq ends idle", {cpu_clk_en, osc_en, wdt_clk_en}, 3'b111);
        enter_pd();
        chk("R6 power-down watchdog off", wdt_clk_en, 0);

        // R7 disabled pin ignored in power-down
        port_pins[1] = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 disabled pin ignored", {osc_en, resume_rst}, 2'b00);
        port_pins = '1;

        // R10 resume pulse length, oscillator on
        port_pins[0] = 1'b0;
        @(negedge clk);
        port_pins = '1;
        begin
            int n = 0;
            int osc_bad = 0;
            while (resume_rst && n < 100) begin
                n++;
                if (!osc_en) osc_bad++;
                @(negedge clk);
            end
            chk("R10 resume pulse length", n, RLEN);
            chk("R10 oscillator on in resume", osc_bad, 0);
        end
        chk("R10 running after resume", {cpu_clk_en, osc_en}, 2'b11);

        // R7 low pin while running has no effect
        port_pins[0] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 pin ignored while running", {cpu_clk_en, osc_en, resume_rst}, 3'b110);
        port_pins = '1;

        // R8 timer select 1: WBASE ticks
        wr(2'd3, 8'h01);
        enter_pd();
        for (int t = 0; t < WBASE - 1; t++) begin tick(); @(negedge clk); end
        chk("R8 sel1 before last tick", {osc_en, resume_rst}, 2'b00);
        tick();
        chk("R8 sel1 last tick", resume_rst, 1);
        repeat (RLEN + 1) @(negedge clk);

        // R8 timer select 2: 2*WBASE ticks
        wr(2'd3, 8'h02);
        enter_pd();
        for (int t = 0; t < 2 * WBASE - 1; t++) begin tick(); @(negedge clk); end
        chk("R8 sel2 before last tick", {osc_en, resume_rst}, 2'b00);
        tick();
        chk("R8 sel2 last tick", resume_rst, 1);
        repeat (RLEN + 1) @(negedge clk);

        // R8 timer disabled
        wr(2'd3, 8'h00);
        enter_pd();
        for (int t = 0; t < 5 * WBASE; t++) begin tick(); @(negedge clk); end
        chk("R8 timer off no wake", {osc_en, resume_rst}, 2'b00);
        recover();

        // R9 USB activity window with restart
        enter_pd();
        usb_nonidle = 1'b1;
        repeat (UCYC - 1) @(negedge clk);
        usb_nonidle = 1'b0;
        @(negedge clk);
        chk("R9 short activity no wake", {osc_en, resume_rst}, 2'b00);
        usb_nonidle = 1'b1;
        repeat (UCYC) @(negedge clk);
        usb_nonidle = 1'b0;
        chk("R9 full window wakes", resume_rst, 1);
        repeat (RLEN + 1) @(negedge clk);
        chk("R9 R10 back to run", {cpu_clk_en, osc_en, resume_rst}, 3'b110);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule